// File: doc/BRIEF.md
# Queue Head Overlay Controller

This block is the control state machine that a schedule walker invokes each time it visits a queue head in memory. On a visit it fetches the queue head into a local cache. Words 4 to 11 of that cache are the transfer overlay, which has the same shape as a transfer descriptor: next pointer, alternate pointer, a status token and five buffer words. Word 3 is the pointer to the descriptor that the overlay was copied from, and word 0 is the horizontal link to the next queue head.

If the overlay holds no active transfer, the controller can optionally advance the queue. It copies a fresh descriptor into the overlay and records its address in word 3. Otherwise it hands the horizontal link back to the walker. While a transfer runs, every transaction result from the execution engine is folded into the cached status token. On completion the overlay is copied to the descriptor named by word 3, and then the queue head's working area (words 3 to 11) is stored back. Memory is reached through a single-request word interface: a request is held until it is acknowledged, and only one request is ever outstanding.

Status token encoding, used throughout: bit 7 = active, bit 6 = halted, bits 11:10 = error budget, bits 30:16 = bytes remaining. A pointer word whose bit 0 is set is a terminate marker. When a pointer is used as an address, bits 4:0 are cleared.

Top module: `qh_overlay_ctrl`

## Requirements
- R1: After reset the block is idle: `mem_req`, `busy`, `executing` and `visit_done` are all low.
- R2: A pulse on `visit_start` reads queue-head words 0 to 11 at `qh_base + 4*i` in ascending order. Each request keeps its address and direction stable until `mem_ack`, and no write is issued while words are being fetched.
- R3: If the overlay token is not active and no advance takes place, the visit ends without further reads or any write. `visit_done` pulses for one cycle, and `next_qh_addr` equals word 0 with bits 4:0 cleared.
- R4: With `advance_en` high, an inactive and non-halted overlay advances the queue by reading 8 words from the chosen pointer with bits 4:0 cleared. The alternate pointer (overlay word 1) is chosen when the token's bytes remaining are non-zero and its bit 0 is clear. Otherwise the next pointer (overlay word 0) is chosen, and only when its bit 0 is clear.
- R5: Advancing sets cached word 3 to the aligned descriptor address. If the loaded token is active, execution follows. If it is not, the visit ends without a second advance.
- R6: An overlay whose token has the halted bit set is never advanced.
- R7: In execution, a non-error transaction subtracts `xact_bytes` from bytes remaining, saturating at 0. Reaching 0, or a transaction flagged `xact_short`, clears the active bit.
- R8: A transaction with `xact_err` decrements an error budget greater than 1. A budget of 1 or 0 becomes 0 with halted set and active cleared, and bytes remaining are left untouched.
- R9: When the active bit clears, the 8 overlay words are written to `{word3[31:5],5'b0} + 4*i` in ascending order. Queue-head words 3 to 11 are then written to `qh_base + 4*i` in ascending order, and the visit ends.
- R10: `xact_yield` during execution (without `xact_valid`) writes only queue-head words 3 to 11, keeping the partial status with active still set, and ends the visit.
- R11: Transaction inputs are ignored outside execution.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| visit_start | input | 1 | Begin a visit of the queue head at `qh_base` |
| qh_base | input | 32 | Queue head byte address (32-byte aligned) |
| advance_en | input | 1 | Permit advancing the queue on this visit |
| busy | output | 1 | A visit is in progress |
| executing | output | 1 | Transaction results are being accepted |
| visit_done | output | 1 | One-cycle pulse at the end of a visit |
| next_qh_addr | output | 32 | Aligned horizontal link, valid with `visit_done` |
| xact_valid | input | 1 | One transaction result is presented |
| xact_bytes | input | 15 | Bytes moved by the transaction |
| xact_err | input | 1 | The transaction failed |
| xact_short | input | 1 | The transaction ended the transfer early |
| xact_yield | input | 1 | Leave the queue head with the transfer still active |
| mem_req | output | 1 | Memory word request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word byte address |
| mem_wdata | output | 32 | Write data |
| mem_ack | input | 1 | Request accepted this cycle; read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
Visits are run against queue heads that differ in just the points the decision hinges on: an inactive token with advancing off, a halted token with a valid next pointer, an inactive token whose short-completion residue steers the advance to the alternate pointer, and an active token reached either directly or after an advance. The logged read and write address streams tell these paths apart: the number of words, the base each run starts from, and whether the descriptor copy precedes the queue-head store. The transaction patterns cover full byte completion over two steps, a short completion, two errors that exhaust the budget, and a partial transfer followed by a yield with a stray result injected during the fetch. Together these separate byte arithmetic, error accounting and the ignore rule. Some visits run with a stalling acknowledge, so held requests are exercised.

// File: rtl/qhov_pkg.sv
package qhov_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_READ_OVL,
    ST_CHECK,
    ST_ADVANCE,
    ST_EXEC,
    ST_WRITEBACK,
    ST_SAVE_QH,
    ST_NEXT_QH
  } qh_state_e;

  // status token field positions
  localparam int TOK_HALTED   = 6;
  localparam int TOK_ACTIVE   = 7;
  localparam int TOK_CERR_LO  = 10;
  localparam int TOK_CERR_W   = 2;
  localparam int TOK_BYTES_LO = 16;
  localparam int TOK_BYTES_W  = 15;

  // pointers are aligned to 2**PTR_LSB bytes
  localparam int PTR_LSB = 5;

  function automatic logic [31:0] align_ptr(input logic [31:0] p);
    return {p[31:PTR_LSB], {PTR_LSB{1'b0}}};
  endfunction

endpackage

// File: rtl/qhov_mem_seq.sv
module qhov_mem_seq
  import qhov_pkg::*;
#(
  parameter int AW    = 32,
  parameter int IDX_W = 4
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             go,
  input  logic             go_we,
  input  logic [AW-1:0]    go_base,
  input  logic [IDX_W-1:0] go_first,
  input  logic [IDX_W-1:0] go_last,
  input  logic             mem_ack,
  output logic             mem_req,
  output logic             mem_we,
  output logic [AW-1:0]    mem_addr,
  output logic [IDX_W-1:0] cur_idx,
  output logic             rd_valid,
  output logic             done
);

  logic             active_q, active_d;
  logic             we_q, we_d;
  logic [AW-1:0]    base_q, base_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic [IDX_W-1:0] last_q, last_d;
  logic             beat;
  logic             at_last;

  assign beat     = active_q & mem_ack;
  assign at_last  = (idx_q == last_q);
  assign mem_req  = active_q;
  assign mem_we   = we_q;
  assign mem_addr = base_q + (AW'(idx_q) << 2);
  assign cur_idx  = idx_q;
  assign rd_valid = beat & ~we_q;
  assign done     = beat & at_last;

  always_comb begin
    active_d = active_q;
    we_d     = we_q;
    base_d   = base_q;
    idx_d    = idx_q;
    last_d   = last_q;
    if (go) begin
      active_d = 1'b1;
      we_d     = go_we;
      base_d   = go_base;
      idx_d    = go_first;
      last_d   = go_last;
    end else if (beat) begin
      if (at_last) active_d = 1'b0;
      else         idx_d    = idx_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      active_q <= 1'b0;
      we_q     <= 1'b0;
      base_q   <= '0;
      idx_q    <= '0;
      last_q   <= '0;
    end else begin
      active_q <= active_d;
      we_q     <= we_d;
      base_q   <= base_d;
      idx_q    <= idx_d;
      last_q   <= last_d;
    end
  end

  // R2: a request not yet acknowledged stays put
  p_req_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)));

  // R2: addresses climb one word per accepted beat
  p_addr_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (beat && !at_last && !go) |=> (mem_addr == $past(mem_addr) + 32'd4));

endmodule

// File: rtl/qhov_token_upd.sv
module qhov_token_upd
  import qhov_pkg::*;
(
  input  logic [31:0]            tok_in,
  input  logic [TOK_BYTES_W-1:0] xbytes,
  input  logic                   xerr,
  input  logic                   xshort,
  output logic [31:0]            tok_out,
  output logic                   finished
);

  logic [TOK_BYTES_W-1:0] bytes_left;
  logic [TOK_CERR_W-1:0]  cerr;

  assign bytes_left = tok_in[TOK_BYTES_LO +: TOK_BYTES_W];
  assign cerr       = tok_in[TOK_CERR_LO +: TOK_CERR_W];

  always_comb begin
    tok_out = tok_in;
    if (xerr) begin
      if (cerr <= TOK_CERR_W'(1)) begin
        tok_out[TOK_CERR_LO +: TOK_CERR_W] = '0;
        tok_out[TOK_HALTED]                = 1'b1;
        tok_out[TOK_ACTIVE]                = 1'b0;
      end else begin
        tok_out[TOK_CERR_LO +: TOK_CERR_W] = cerr - 1'b1;
      end
    end else begin
      if (xbytes >= bytes_left) begin
        tok_out[TOK_BYTES_LO +: TOK_BYTES_W] = '0;
        tok_out[TOK_ACTIVE]                  = 1'b0;
      end else begin
        tok_out[TOK_BYTES_LO +: TOK_BYTES_W] = bytes_left - xbytes;
        if (xshort) tok_out[TOK_ACTIVE] = 1'b0;
      end
    end
    finished = ~tok_out[TOK_ACTIVE];
  end

endmodule

// File: rtl/qh_overlay_ctrl.sv
module qh_overlay_ctrl
  import qhov_pkg::*;
#(
  parameter int AW       = 32,
  parameter int DW       = 32,
  parameter int QH_WORDS = 12,
  parameter int OV_BASE  = 4,
  parameter int CUR_WORD = 3
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   visit_start,
  input  logic [AW-1:0]          qh_base,
  input  logic                   advance_en,
  output logic                   busy,
  output logic                   executing,
  output logic                   visit_done,
  output logic [AW-1:0]          next_qh_addr,
  input  logic                   xact_valid,
  input  logic [TOK_BYTES_W-1:0] xact_bytes,
  input  logic                   xact_err,
  input  logic                   xact_short,
  input  logic                   xact_yield,
  output logic                   mem_req,
  output logic                   mem_we,
  output logic [AW-1:0]          mem_addr,
  output logic [DW-1:0]          mem_wdata,
  input  logic                   mem_ack,
  input  logic [DW-1:0]          mem_rdata
);

  localparam int IDX_W    = $clog2(QH_WORDS);
  localparam int OV_WORDS = QH_WORDS - OV_BASE;
  localparam int TOK_WORD = OV_BASE + 2;
  localparam int NXT_WORD = OV_BASE;
  localparam int ALT_WORD = OV_BASE + 1;
  localparam logic [IDX_W-1:0] IDX_ZERO = '0;
  localparam logic [IDX_W-1:0] IDX_QLST = IDX_W'(QH_WORDS - 1);
  localparam logic [IDX_W-1:0] IDX_OLST = IDX_W'(OV_WORDS - 1);
  localparam logic [IDX_W-1:0] IDX_CUR  = IDX_W'(CUR_WORD);

  qh_state_e        state_q, state_d;
  logic [AW-1:0]    qh_q, qh_d;
  logic             advanced_q, advanced_d;
  logic [DW-1:0]    cache_q [QH_WORDS];

  logic             seq_go, seq_we;
  logic [AW-1:0]    seq_base;
  logic [IDX_W-1:0] seq_first, seq_last, seq_idx, wr_idx;
  logic             seq_rd_valid, seq_done;

  logic             c_we;
  logic [IDX_W-1:0] c_idx;
  logic [DW-1:0]    c_data;

  logic [DW-1:0]    tok, tok_new, sel_ptr;
  logic             tok_finished, use_alt;

  qhov_mem_seq #(.AW(AW), .IDX_W(IDX_W)) u_seq (
    .clk      (clk),
    .rst_n    (rst_n),
    .go       (seq_go),
    .go_we    (seq_we),
    .go_base  (seq_base),
    .go_first (seq_first),
    .go_last  (seq_last),
    .mem_ack  (mem_ack),
    .mem_req  (mem_req),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .cur_idx  (seq_idx),
    .rd_valid (seq_rd_valid),
    .done     (seq_done)
  );

  assign tok = cache_q[TOK_WORD];

  qhov_token_upd u_tok (
    .tok_in   (tok),
    .xbytes   (xact_bytes),
    .xerr     (xact_err),
    .xshort   (xact_short),
    .tok_out  (tok_new),
    .finished (tok_finished)
  );

  // alternate pointer after a short completion, next pointer otherwise
  assign use_alt = (tok[TOK_BYTES_LO +: TOK_BYTES_W] != '0) && !cache_q[ALT_WORD][0];
  assign sel_ptr = use_alt ? cache_q[ALT_WORD] : cache_q[NXT_WORD];

  // overlay words sit OV_BASE above the descriptor word index
  assign wr_idx    = (state_q == ST_WRITEBACK) ? IDX_W'(seq_idx + OV_BASE) : seq_idx;
  assign mem_wdata = cache_q[wr_idx];

  assign busy         = (state_q != ST_IDLE);
  assign executing    = (state_q == ST_EXEC);
  assign visit_done   = (state_q == ST_NEXT_QH);
  assign next_qh_addr = align_ptr(cache_q[0]);

  always_comb begin
    state_d    = state_q;
    qh_d       = qh_q;
    advanced_d = advanced_q;
    seq_go     = 1'b0;
    seq_we     = 1'b0;
    seq_base   = '0;
    seq_first  = IDX_ZERO;
    seq_last   = IDX_ZERO;
    c_we       = 1'b0;
    c_idx      = IDX_ZERO;
    c_data     = '0;

    if (seq_rd_valid) begin
      c_we   = 1'b1;
      c_idx  = (state_q == ST_ADVANCE) ? IDX_W'(seq_idx + OV_BASE) : seq_idx;
      c_data = mem_rdata;
    end

    case (state_q)
      ST_IDLE: begin
        if (visit_start) begin
          qh_d       = qh_base;
          advanced_d = 1'b0;
          seq_go     = 1'b1;
          seq_base   = qh_base;
          seq_first  = IDX_ZERO;
          seq_last   = IDX_QLST;
          state_d    = ST_READ_OVL;
        end
      end
      ST_READ_OVL: begin
        if (seq_done) state_d = ST_CHECK;
      end
      ST_CHECK: begin
        if (tok[TOK_ACTIVE]) begin
          state_d = ST_EXEC;
        end else if (advance_en && !advanced_q && !tok[TOK_HALTED] && !sel_ptr[0]) begin
          advanced_d = 1'b1;
          seq_go     = 1'b1;
          seq_base   = align_ptr(sel_ptr);
          seq_first  = IDX_ZERO;
          seq_last   = IDX_OLST;
          c_we       = 1'b1;
          c_idx      = IDX_CUR;
          c_data     = align_ptr(sel_ptr);
          state_d    = ST_ADVANCE;
        end else begin
          state_d = ST_NEXT_QH;
        end
      end
      ST_ADVANCE: begin
        if (seq_done) state_d = ST_CHECK;
      end
      ST_EXEC: begin
        if (xact_valid) begin
          c_we   = 1'b1;
          c_idx  = IDX_W'(TOK_WORD);
          c_data = tok_new;
          if (tok_finished) begin
            seq_go    = 1'b1;
            seq_we    = 1'b1;
            seq_base  = align_ptr(cache_q[CUR_WORD]);
            seq_first = IDX_ZERO;
            seq_last  = IDX_OLST;
            state_d   = ST_WRITEBACK;
          end
        end else if (xact_yield) begin
          seq_go    = 1'b1;
          seq_we    = 1'b1;
          seq_base  = qh_q;
          seq_first = IDX_CUR;
          seq_last  = IDX_QLST;
          state_d   = ST_SAVE_QH;
        end
      end
      ST_WRITEBACK: begin
        if (seq_done) begin
          seq_go    = 1'b1;
          seq_we    = 1'b1;
          seq_base  = qh_q;
          seq_first = IDX_CUR;
          seq_last  = IDX_QLST;
          state_d   = ST_SAVE_QH;
        end
      end
      ST_SAVE_QH: begin
        if (seq_done) state_d = ST_NEXT_QH;
      end
      ST_NEXT_QH: state_d = ST_IDLE;
      default:    state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= ST_IDLE;
      qh_q       <= '0;
      advanced_q <= 1'b0;
      for (int i = 0; i < QH_WORDS; i++) cache_q[i] <= '0;
    end else begin
      state_q    <= state_d;
      qh_q       <= qh_d;
      advanced_q <= advanced_d;
      if (c_we) cache_q[c_idx] <= c_data;
    end
  end

  // R2: fetch phases never write
  p_fetch_no_write_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_READ_OVL || state_q == ST_ADVANCE) && mem_req) |-> !mem_we);

  // R3: the decision cycle has no memory traffic
  p_check_quiet_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK) |-> !mem_req);

  // R3: end-of-visit is a single-cycle pulse with the bus idle
  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
    visit_done |=> (!visit_done && !mem_req));

  // R5: at most one advance per visit
  p_single_adv_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && advanced_q) |=> (state_q != ST_ADVANCE));

  // R6: a halted overlay is left alone
  p_halt_no_adv_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_CHECK && tok[TOK_HALTED] && !tok[TOK_ACTIVE]) |=> (state_q != ST_ADVANCE));

  // R7: execution only runs on an active token
  p_exec_active_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_EXEC) |-> tok[TOK_ACTIVE]);

  // R9: copy-back phases only write
  p_wb_writes_r9: assert property (@(posedge clk) disable iff (!rst_n)
    ((state_q == ST_WRITEBACK || state_q == ST_SAVE_QH) && mem_req) |-> mem_we);

endmodule

// File: tb/qh_overlay_ctrl_tb.sv
`timescale 1ns/1ps
module qh_overlay_ctrl_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        visit_start;
  logic [31:0] qh_base;
  logic        advance_en;
  logic        busy, executing, visit_done;
  logic [31:0] next_qh_addr;
  logic        xact_valid;
  logic [14:0] xact_bytes;
  logic        xact_err, xact_short, xact_yield;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic        mem_ack;
  logic [31:0] mem_rdata;

  always #2.5 clk = ~clk;

  qh_overlay_ctrl dut_i (
    .clk(clk), .rst_n(rst_n), .visit_start(visit_start), .qh_base(qh_base),
    .advance_en(advance_en), .busy(busy), .executing(executing),
    .visit_done(visit_done), .next_qh_addr(next_qh_addr),
    .xact_valid(xact_valid), .xact_bytes(xact_bytes), .xact_err(xact_err),
    .xact_short(xact_short), .xact_yield(xact_yield),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] mem [1024];
  logic [31:0] wr_addr [64];
  logic [31:0] wr_data [64];
  logic [31:0] rd_addr [64];
  int n_wr = 0;
  int n_rd = 0;
  int cyc = 0;
  logic stall_en = 1'b0;
  logic [31:0] last_next;

  // memory model: acknowledge away from the active edge
  always @(negedge clk) begin
    cyc = cyc + 1;
    mem_ack = mem_req && (!stall_en || (cyc % 3 != 0));
    if (mem_ack) begin
      if (mem_we) begin
        mem[mem_addr[11:2]] = mem_wdata;
        if (n_wr < 64) begin wr_addr[n_wr] = mem_addr; wr_data[n_wr] = mem_wdata; end
        n_wr = n_wr + 1;
      end else begin
        if (n_rd < 64) rd_addr[n_rd] = mem_addr;
        n_rd = n_rd + 1;
      end
    end
    mem_rdata = mem[mem_addr[11:2]];
  end

  always @(posedge clk) begin
    if (cyc > 100000) begin
      n_bad = n_bad + 1;
      $display("FAIL watchdog expired");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk + 1, n_bad);
      $finish;
    end
  end

  function automatic logic [31:0] tok(input logic act, input logic hlt,
                                      input logic [1:0] ce, input logic [14:0] by);
    return {1'b0, by, 4'b0, ce, 2'b0, act, hlt, 6'b0};
  endfunction

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk = n_chk + 1;
    if (act !== exp) begin
      n_bad = n_bad + 1;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr_mem(input logic [31:0] a, input logic [31:0] d);
    mem[a[11:2]] = d;
  endtask

  task automatic clear_logs();
    n_wr = 0;
    n_rd = 0;
  endtask

  task automatic set_qh(input logic [31:0] w0, input logic [31:0] w3, input logic [31:0] nxt,
                        input logic [31:0] alt, input logic [31:0] t);
    wr_mem(32'h100, w0); wr_mem(32'h104, 32'h11); wr_mem(32'h108, 32'h22);
    wr_mem(32'h10C, w3); wr_mem(32'h110, nxt); wr_mem(32'h114, alt);
    wr_mem(32'h118, t);
    for (int i = 0; i < 5; i++) wr_mem(32'h11C + 4 * i, 32'hA0 + i);
  endtask

  task automatic start_visit(input logic adv);
    clear_logs();
    @(negedge clk);
    advance_en  = adv;
    qh_base     = 32'h100;
    visit_start = 1'b1;
    @(negedge clk);
    visit_start = 1'b0;
  endtask

  task automatic wait_exec(input string req);
    int n = 0;
    while (!executing && n < 400) begin @(negedge clk); n++; end
    chk(req, {31'b0, executing}, 32'd1);
  endtask

  task automatic wait_done(input string req);
    int n = 0;
    while (!visit_done && n < 400) begin @(negedge clk); n++; end
    chk(req, {31'b0, visit_done}, 32'd1);
    last_next = next_qh_addr;
    @(negedge clk);
  endtask

  task automatic pulse(input logic [14:0] b, input logic e, input logic s, input logic y);
    xact_valid = ~y; xact_bytes = b; xact_err = e; xact_short = s; xact_yield = y;
    @(negedge clk);
    xact_valid = 1'b0; xact_err = 1'b0; xact_short = 1'b0; xact_yield = 1'b0;
    @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 mem_req", {31'b0, mem_req}, 32'd0);
    chk("R1 busy", {31'b0, busy}, 32'd0);
    chk("R1 executing", {31'b0, executing}, 32'd0);
    chk("R1 visit_done", {31'b0, visit_done}, 32'd0);
  endtask

  // R2 R3: inactive overlay, advancing off, valid next pointer present
  task automatic t_pass_through();
    stall_en = 1'b1;
    set_qh(32'h0000_0462, 32'h300, 32'h200, 32'h1, 32'h0);
    start_visit(1'b0);
    wait_done("R3 done");
    chk("R3 next_qh_addr", last_next, 32'h460);
    chk("R2 read count", n_rd, 12);
    chk("R2 first read", rd_addr[0], 32'h100);
    chk("R2 last read", rd_addr[11], 32'h12C);
    chk("R3 no writes", n_wr, 0);
    stall_en = 1'b0;
  endtask

  // R4 R5 R7 R9: advance via next pointer, two-step completion
  task automatic t_advance_exec();
    set_qh(32'h0000_0460, 32'h300, 32'h200, 32'h1, 32'h0);
    wr_mem(32'h200, 32'h1); wr_mem(32'h204, 32'h1); wr_mem(32'h208, tok(1, 0, 3, 100));
    for (int i = 0; i < 5; i++) wr_mem(32'h20C + 4 * i, 32'hB0 + i);
    start_visit(1'b1);
    wait_exec("R5 exec after advance");
    chk("R4 desc read base", rd_addr[12], 32'h200);
    pulse(15'd40, 1'b0, 1'b0, 1'b0);
    chk("R7 still executing", {31'b0, executing}, 32'd1);
    pulse(15'd60, 1'b0, 1'b0, 1'b0);
    wait_done("R9 done");
    chk("R4 read count", n_rd, 20);
    chk("R9 write count", n_wr, 17);
    chk("R9 first desc addr", wr_addr[0], 32'h200);
    chk("R9 last desc addr", wr_addr[7], 32'h21C);
    chk("R7 desc token", mem[32'h208 >> 2], tok(0, 0, 3, 0));
    chk("R9 qh store addr", wr_addr[8], 32'h10C);
    chk("R5 qh word3", mem[32'h10C >> 2], 32'h200);
    chk("R9 qh token", wr_data[11], tok(0, 0, 3, 0));
    chk("R9 qh last word", wr_data[16], 32'hB4);
  endtask

  // R8 R9: error budget exhausted, word3 low bits ignored
  task automatic t_errors();
    stall_en = 1'b1;
    set_qh(32'h0000_0460, 32'h24B, 32'h1, 32'h1, tok(1, 0, 2, 64));
    start_visit(1'b0);
    wait_exec("R8 exec");
    pulse(15'd0, 1'b1, 1'b0, 1'b0);
    chk("R8 one error keeps running", {31'b0, executing}, 32'd1);
    pulse(15'd0, 1'b1, 1'b0, 1'b0);
    wait_done("R8 done");
    chk("R9 aligned base", wr_addr[0], 32'h240);
    chk("R8 halted token", mem[32'h248 >> 2], tok(0, 1, 0, 64));
    stall_en = 1'b0;
  endtask

  // R10 R11: stray result during fetch, partial transfer, yield
  task automatic t_yield();
    set_qh(32'h0000_0460, 32'h280, 32'h1, 32'h1, tok(1, 0, 3, 50));
    start_visit(1'b0);
    pulse(15'd10, 1'b0, 1'b0, 1'b0);
    wait_exec("R10 exec");
    pulse(15'd20, 1'b0, 1'b0, 1'b0);
    pulse(15'd0, 1'b0, 1'b0, 1'b1);
    wait_done("R10 done");
    chk("R10 write count", n_wr, 9);
    chk("R10 first write", wr_addr[0], 32'h10C);
    chk("R11 token partial", mem[32'h118 >> 2], tok(1, 0, 3, 30));
  endtask

  // R7 short completion, then R4 R5 alternate advance without a second advance
  task automatic t_short_then_alt();
    set_qh(32'h0000_0460, 32'h2C0, 32'h200, 32'h280, tok(1, 0, 3, 100));
    wr_mem(32'h280, 32'h200); wr_mem(32'h284, 32'h1); wr_mem(32'h288, tok(0, 0, 3, 0));
    start_visit(1'b0);
    wait_exec("R7 exec");
    pulse(15'd30, 1'b0, 1'b1, 1'b0);
    wait_done("R7 done");
    chk("R7 short token", mem[32'h2C8 >> 2], tok(0, 0, 3, 70));
    start_visit(1'b1);
    wait_done("R5 done");
    chk("R4 alt base", rd_addr[12], 32'h280);
    chk("R5 single advance", n_rd, 20);
    chk("R5 no writes", n_wr, 0);
  endtask

  // R6: halted overlay with valid next pointer and advancing on
  task automatic t_halted();
    set_qh(32'h0000_0460, 32'h300, 32'h200, 32'h1, tok(0, 1, 0, 5));
    start_visit(1'b1);
    wait_done("R6 done");
    chk("R6 no advance reads", n_rd, 12);
    chk("R6 no writes", n_wr, 0);
  endtask

  initial begin
    for (int i = 0; i < 1024; i++) mem[i] = 32'h0;
    rst_n = 1'b0; visit_start = 1'b0; qh_base = 32'h0; advance_en = 1'b0;
    xact_valid = 1'b0; xact_bytes = 15'd0; xact_err = 1'b0;
    xact_short = 1'b0; xact_yield = 1'b0;
    mem_ack = 1'b0; mem_rdata = 32'h0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_pass_through();
    t_advance_exec();
    t_errors();
    t_yield();
    t_short_then_alt();
    t_halted();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

endmodule